// File: doc/BRIEF.md
# Run/Pause/Reset State Controller

This block is the register-mapped control and status front end of a serial-bus engine. Software moves the engine between three operating states (reset, run and pause) by writing a state register. A requested change does not apply at once. It first waits a fixed number of interface-clock cycles, then a fixed number of engine-clock ticks. The engine clock arrives as a one-cycle enable pulse, `eng_tick`, in the interface domain. While the change is settling, a valid bit in the state register reads low, so software polls it before it issues the next state write.

The block also carries the following:

- a self-clearing software reset;
- live FIFO status flags;
- sticky service flags, cleared by writing 1 to their bit;
- sticky core error flags behind an enable mask;
- sticky bus-error flags, cleared by moving back to the reset state.

Any pending flag drives a level interrupt. In pause the engine enable is low, but out-FIFO writes from the register port are still passed on, so software can refill the FIFO while the bus is frozen.

Top module: `run_state_ctl`

## Requirements
- R1: After reset the state field reads 0 (reset), the valid bit reads 1, `eng_en`, `irq` and `soft_rst` are low, and every sticky flag reads 0.
- R2: The state register at 0x004 holds the state code in bits [1:0] (0 reset, 1 run, 3 pause), the valid bit in bit 2 and the live `master_ready` input in bit 4. A write of code 0, 1 or 3 while valid is high is accepted. Valid reads low from the next cycle. `state_o` keeps its old value until IF_SETTLE interface cycles and then ENG_SETTLE `eng_tick` pulses have passed, and then changes together with valid rising.
- R3: A write to the state register while valid is low, or a write of code 2, leaves the state and the valid bit unchanged.
- R4: `eng_en` is high only while the current state is run. It is low in pause and in reset.
- R5: A write to 0x110 raises `out_push` with `out_data` equal to the written word in the same cycle, in run and in pause, but not in reset. A read of 0x218 returns `in_data` and raises `in_pop` in the same cycle.
- R6: The register at 0x018 shows the following live inputs: out-FIFO not empty (bit 4), in-FIFO not empty (bit 5), out-FIFO full (bit 6), output count reached (bit 10) and input count reached (bit 11). Bits 8 (output service) and 9 (input service) are sticky, are set by the event inputs, and are cleared by writing 1 to the same bit. Writing 0 to a service bit leaves it set.
- R7: Bits [6:2] of 0x01c are sticky core error flags, set by `core_err_evt[4:0]` and cleared by writing 1 to the bit. Bits [6:2] of 0x020 are read/write enables for those flags.
- R8: `irq` is high exactly when either service flag is set, any bus-error flag is set, or any core error flag is set together with its enable bit. A disabled core error does not raise `irq`.
- R9: Bits [BERR_W-1:0] of 0x404 are sticky bus-error flags set by `bus_err_evt`. They are cleared by an accepted write of the reset code to the state register.
- R10: A write with bit 0 set to 0x00c forces the state to reset with valid high from the next cycle. It cancels any pending transition, clears all sticky flags and enables so that `irq` is low, and pulses `soft_rst` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eng_tick | input | 1 | One-cycle pulse per engine clock |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (causes pops) |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| master_ready | input | 1 | Engine master generator ready |
| out_not_empty | input | 1 | Out FIFO holds data |
| in_not_empty | input | 1 | In FIFO holds data |
| out_full | input | 1 | Out FIFO full |
| out_max_done | input | 1 | Output count reached |
| in_max_done | input | 1 | Input count reached |
| out_svc_evt | input | 1 | Output service request pulse |
| in_svc_evt | input | 1 | Input service request pulse |
| core_err_evt | input | 5 | Core error event pulses |
| bus_err_evt | input | BERR_W | Bus protocol error event pulses |
| out_push | output | 1 | Push strobe to the out FIFO |
| out_data | output | 32 | Word pushed to the out FIFO |
| in_pop | output | 1 | Pop strobe to the in FIFO |
| in_data | input | 32 | Head word of the in FIFO |
| state_o | output | 2 | Current effective state |
| valid_o | output | 1 | High when no transition is pending |
| eng_en | output | 1 | Engine run enable |
| soft_rst | output | 1 | One-cycle reset pulse to the engine |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the controller with IF_SETTLE=2 and ENG_SETTLE=5, so that the two settle phases have unequal lengths. With these values a transition under a continuous engine tick must take exactly seven cycles, and a miscounted phase shows up as a latency error. The bench also holds `eng_tick` low for a long stretch to show that valid waits on the engine side. BERR_W is kept at 4, so the bus-error field and its clear by a reset-code write are read back whole through 0x404.

// File: rtl/run_state_ctl.sv
module run_state_ctl #(
  parameter int IF_SETTLE  = 3,
  parameter int ENG_SETTLE = 3,
  parameter int BERR_W     = 4,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_tick,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              master_ready,
  input  logic              out_not_empty,
  input  logic              in_not_empty,
  input  logic              out_full,
  input  logic              out_max_done,
  input  logic              in_max_done,
  input  logic              out_svc_evt,
  input  logic              in_svc_evt,
  input  logic [4:0]        core_err_evt,
  input  logic [BERR_W-1:0] bus_err_evt,
  output logic              out_push,
  output logic [31:0]       out_data,
  output logic              in_pop,
  input  logic [31:0]       in_data,
  output logic [1:0]        state_o,
  output logic              valid_o,
  output logic              eng_en,
  output logic              soft_rst,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_STATE = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] A_SWRST = ADDR_W'(12'h00c);
  localparam logic [ADDR_W-1:0] A_OPS   = ADDR_W'(12'h018);
  localparam logic [ADDR_W-1:0] A_ERR   = ADDR_W'(12'h01c);
  localparam logic [ADDR_W-1:0] A_ERREN = ADDR_W'(12'h020);
  localparam logic [ADDR_W-1:0] A_OFIFO = ADDR_W'(12'h110);
  localparam logic [ADDR_W-1:0] A_IFIFO = ADDR_W'(12'h218);
  localparam logic [ADDR_W-1:0] A_BERR  = ADDR_W'(12'h404);
  localparam int IFW  = $clog2(IF_SETTLE + 1);
  localparam int ENW  = $clog2(ENG_SETTLE + 1);
  localparam logic [1:0] S_RESET = 2'd0;
  localparam logic [1:0] S_RUN   = 2'd1;

  logic [1:0]        cur, tgt;
  logic              valid, in_eng;
  logic [IFW-1:0]    cif;
  logic [ENW-1:0]    ceng;
  logic              svc_out, svc_in;
  logic [4:0]        cerr, cerr_en;
  logic [BERR_W-1:0] berr;

  wire sw_hit  = reg_wr && reg_addr == A_SWRST && reg_wdata[0];
  wire st_hit  = reg_wr && reg_addr == A_STATE && valid && reg_wdata[1:0] != 2'd2;
  wire ops_wr  = reg_wr && reg_addr == A_OPS;
  wire err_wr  = reg_wr && reg_addr == A_ERR;
  wire to_rst  = st_hit && reg_wdata[1:0] == S_RESET;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= S_RESET; tgt <= S_RESET; valid <= 1'b1; in_eng <= 1'b0;
      cif <= '0; ceng <= '0;
    end else if (sw_hit) begin
      cur <= S_RESET; tgt <= S_RESET; valid <= 1'b1; in_eng <= 1'b0;
      cif <= '0; ceng <= '0;
    end else if (st_hit) begin
      tgt <= reg_wdata[1:0]; valid <= 1'b0; in_eng <= 1'b0;
      cif <= '0; ceng <= '0;
    end else if (!valid) begin
      if (!in_eng) begin
        if (cif == IFW'(IF_SETTLE - 1)) in_eng <= 1'b1;
        else cif <= cif + 1'b1;
      end else if (eng_tick) begin
        if (ceng == ENW'(ENG_SETTLE - 1)) begin
          cur <= tgt; valid <= 1'b1; in_eng <= 1'b0;
        end else ceng <= ceng + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      svc_out <= 1'b0; svc_in <= 1'b0; cerr <= '0; cerr_en <= '0;
      berr <= '0; soft_rst <= 1'b0;
    end else begin
      soft_rst <= sw_hit;
      if (sw_hit) begin
        svc_out <= 1'b0; svc_in <= 1'b0; cerr <= '0; cerr_en <= '0; berr <= '0;
      end else begin
        svc_out <= out_svc_evt | (svc_out & ~(ops_wr & reg_wdata[8]));
        svc_in  <= in_svc_evt  | (svc_in  & ~(ops_wr & reg_wdata[9]));
        cerr    <= core_err_evt | (cerr & ~({5{err_wr}} & reg_wdata[6:2]));
        if (reg_wr && reg_addr == A_ERREN) cerr_en <= reg_wdata[6:2];
        berr    <= bus_err_evt | (to_rst ? '0 : berr);
      end
    end
  end

  assign state_o  = cur;
  assign valid_o  = valid;
  assign eng_en   = cur == S_RUN;
  assign out_push = reg_wr && reg_addr == A_OFIFO && cur != S_RESET;
  assign out_data = reg_wdata;
  assign in_pop   = reg_rd && reg_addr == A_IFIFO;
  assign irq      = svc_out | svc_in | (|berr) | (|(cerr & cerr_en));

  wire [31:0] ops_word = {20'd0, in_max_done, out_max_done, svc_in, svc_out,
                          1'b0, out_full, in_not_empty, out_not_empty, 4'd0};

  always_comb begin
    unique case (reg_addr)
      A_STATE: reg_rdata = {27'd0, master_ready, 1'b0, valid, cur};
      A_OPS:   reg_rdata = ops_word;
      A_ERR:   reg_rdata = {25'd0, cerr, 2'd0};
      A_ERREN: reg_rdata = {25'd0, cerr_en, 2'd0};
      A_IFIFO: reg_rdata = in_data;
      A_BERR:  reg_rdata = 32'(berr);
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/run_state_ctl_chk.sv
module run_state_ctl_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_wdata,
  input logic [1:0]        state_o,
  input logic              valid_o,
  input logic              eng_en,
  input logic              irq,
  input logic              out_svc_evt
);
  wire st_wr = reg_wr && reg_addr == ADDR_W'(12'h004);
  wire sw_wr = reg_wr && reg_addr == ADDR_W'(12'h00c) && reg_wdata[0];

  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && valid_o && reg_wdata[1:0] != 2'd2) |=> !valid_o); // R2
  AST_LEGAL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> state_o != 2'd2); // R2
  AST_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |=> (valid_o || $stable(state_o))); // R3
  AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    state_o != 2'd1 |-> !eng_en); // R4
  AST_SVC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (out_svc_evt && !sw_wr) |=> irq); // R8
  AST_SWR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> (!irq && valid_o && state_o == 2'd0)); // R10
endmodule

bind run_state_ctl run_state_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .state_o(state_o), .valid_o(valid_o),
  .eng_en(eng_en), .irq(irq), .out_svc_evt(out_svc_evt)
);

// File: tb/run_state_ctl_test.sv
module run_state_ctl_test;
  localparam int IFS = 2, ENS = 5, BW = 4, AW = 12;

  logic clk = 0, rst_n = 0, eng_tick = 1, reg_wr = 0, reg_rd = 0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata, out_data, in_data = '0;
  logic master_ready = 0, out_not_empty = 0, in_not_empty = 0, out_full = 0;
  logic out_max_done = 0, in_max_done = 0, out_svc_evt = 0, in_svc_evt = 0;
  logic [4:0] core_err_evt = '0;
  logic [BW-1:0] bus_err_evt = '0;
  logic out_push, in_pop, valid_o, eng_en, soft_rst, irq;
  logic [1:0] state_o;

  int checks = 0, errors = 0;
  logic seen_push;
  logic [31:0] seen_pdata;

  run_state_ctl #(.IF_SETTLE(IFS), .ENG_SETTLE(ENS), .BERR_W(BW), .ADDR_W(AW)) uut (.*);

  always #2 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1;
    #1 seen_push = out_push; seen_pdata = out_data;
    @(posedge clk); #1 reg_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d, output logic pop);
    @(negedge clk); reg_addr = a; reg_rd = 1;
    #1 d = reg_rdata; pop = in_pop;
    @(posedge clk); #1 reg_rd = 0;
  endtask

  task automatic settle(output int n);
    n = 0;
    while (!valid_o && n < 1000) begin @(posedge clk); #1 n++; end
  endtask

  task automatic go(logic [1:0] code);
    int n;
    wr(12'h004, {30'd0, code});
    settle(n);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic p;
    chk("R1 state", state_o, 0); chk("R1 valid", valid_o, 1);
    chk("R1 irq", irq, 0); chk("R1 eng_en", eng_en, 0); chk("R1 soft_rst", soft_rst, 0);
    rd(12'h018, d, p); chk("R1 ops sticky", d[9:8], 0);
    rd(12'h01c, d, p); chk("R1 err", d, 0);
  endtask

  task automatic t_run_latency;
    int n; logic [31:0] d; logic p;
    master_ready = 1;
    rd(12'h004, d, p); chk("R2 ready bit4", d[4], 1);
    wr(12'h004, 32'd1);
    chk("R2 valid low after write", valid_o, 0);
    rd(12'h004, d, p); chk("R2 valid bit2 low", d[2], 0);
    n = 1;
    while (!valid_o && n < 100) begin
      chk("R2 old state held", state_o, 0);
      @(posedge clk); #1 n++;
    end
    chk("R2 latency", n, IFS + ENS);
    chk("R2 new state", state_o, 1);
    chk("R4 eng_en in run", eng_en, 1);
  endtask

  task automatic t_eng_gate;
    int n;
    eng_tick = 0;
    wr(12'h004, 32'd3);
    repeat (30) @(posedge clk); #1;
    chk("R2 waits for engine ticks", valid_o, 0);
    chk("R2 state held while waiting", state_o, 1);
    eng_tick = 1;
    settle(n);
    chk("R2 ENG_SETTLE ticks", n, ENS);
    chk("R2 pause entered", state_o, 3);
    chk("R4 eng_en low in pause", eng_en, 0);
  endtask

  task automatic t_ignore;
    wr(12'h004, 32'd1);
    wr(12'h004, 32'd0);
    go(2'd1);
    chk("R3 busy write ignored", state_o, 1);
    wr(12'h004, 32'd2);
    chk("R3 code 2 keeps valid", valid_o, 1);
    repeat (10) @(posedge clk); #1;
    chk("R3 code 2 keeps state", state_o, 1);
  endtask

  task automatic t_fifo;
    logic [31:0] d; logic p;
    wr(12'h110, 32'hCAFE0001);
    chk("R5 push in run", seen_push, 1); chk("R5 push data", seen_pdata, 32'hCAFE0001);
    go(2'd3);
    wr(12'h110, 32'h12345678);
    chk("R5 push in pause", seen_push, 1); chk("R5 pause data", seen_pdata, 32'h12345678);
    in_data = 32'hA5A5_0F0F;
    rd(12'h218, d, p);
    chk("R5 pop strobe", p, 1); chk("R5 pop data", d, 32'hA5A50F0F);
    go(2'd0);
    chk("R4 eng_en low in reset", eng_en, 0);
    wr(12'h110, 32'h1);
    chk("R5 no push in reset", seen_push, 0);
  endtask

  task automatic t_ops;
    logic [31:0] d; logic p;
    out_not_empty = 1; in_not_empty = 0; out_full = 1; out_max_done = 0; in_max_done = 1;
    rd(12'h018, d, p);
    chk("R6 live flags", {d[11:10], d[6:4]}, 5'b10_101);
    out_not_empty = 0; in_not_empty = 1; out_full = 0; out_max_done = 1; in_max_done = 0;
    rd(12'h018, d, p);
    chk("R6 live flags 2", {d[11:10], d[6:4]}, 5'b01_010);
    @(negedge clk); out_svc_evt = 1; in_svc_evt = 1; @(posedge clk); #1 out_svc_evt = 0; in_svc_evt = 0;
    rd(12'h018, d, p); chk("R6 svc set", d[9:8], 2'b11);
    chk("R8 irq from svc", irq, 1);
    wr(12'h018, 32'h0000_0100);
    rd(12'h018, d, p); chk("R6 w1c out only", d[9:8], 2'b10);
    wr(12'h018, 32'h0);
    rd(12'h018, d, p); chk("R6 write 0 keeps", d[9:8], 2'b10);
    wr(12'h018, 32'h0000_0200);
    chk("R8 irq cleared", irq, 0);
  endtask

  task automatic t_errs;
    logic [31:0] d; logic p;
    @(negedge clk); core_err_evt = 5'b00101; @(posedge clk); #1 core_err_evt = 0;
    rd(12'h01c, d, p); chk("R7 sticky err", d, 32'h14);
    chk("R8 masked err no irq", irq, 0);
    wr(12'h020, 32'h10);
    rd(12'h020, d, p); chk("R7 enable rw", d, 32'h10);
    chk("R8 enabled err irq", irq, 1);
    wr(12'h01c, 32'h10);
    rd(12'h01c, d, p); chk("R7 w1c err", d, 32'h04);
    chk("R8 irq after w1c", irq, 0);
    wr(12'h01c, 32'h04);
  endtask

  task automatic t_bus;
    logic [31:0] d; logic p;
    go(2'd1);
    @(negedge clk); bus_err_evt = 4'b0100; @(posedge clk); #1 bus_err_evt = 0;
    rd(12'h404, d, p); chk("R9 bus err sticky", d, 4);
    chk("R8 irq from bus err", irq, 1);
    wr(12'h404, 32'hF);
    rd(12'h404, d, p); chk("R9 not cleared by other write", d, 4);
    wr(12'h004, 32'd0);
    rd(12'h404, d, p); chk("R9 cleared by reset code", d, 0);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_swreset;
    logic [31:0] d; logic p;
    go(2'd1);
    wr(12'h020, 32'h7C);
    @(negedge clk); out_svc_evt = 1; core_err_evt = 5'h1F; bus_err_evt = 4'h3;
    @(posedge clk); #1 out_svc_evt = 0; core_err_evt = 0; bus_err_evt = 0;
    wr(12'h004, 32'd3);
    chk("R10 precondition busy", valid_o, 0);
    wr(12'h00c, 32'd1);
    chk("R10 state reset", state_o, 0); chk("R10 valid", valid_o, 1);
    chk("R10 irq low", irq, 0); chk("R10 soft_rst pulse", soft_rst, 1);
    @(posedge clk); #1 chk("R10 soft_rst one cycle", soft_rst, 0);
    rd(12'h020, d, p); chk("R10 enables cleared", d, 0);
    repeat (20) @(posedge clk); #1;
    chk("R10 pending transition cancelled", state_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1 rst_n = 1;
    t_reset; t_run_latency; t_eng_gate; t_ignore; t_fifo;
    t_ops; t_errs; t_bus; t_swreset;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule